// File: doc/BRIEF.md
# Graphics DMA Channel Register Controller

This block is one DMA channel that carries a byte stream into graphics memory. Software programs a destination address and a byte count, then sets the go bit of the control register. The block then takes bytes from a ready/valid input stream and turns each accepted byte into one memory write. Each write goes to the destination plus the index of that byte.

The destination write keeps an aligned window of the written value and always sets a fixed region bit. The count write is rounded down to a whole number of 32-byte blocks. A transfer ends when the programmed count is reached, or earlier when the stream marks a byte as its last. At the end the control and count registers clear and a one-cycle completion pulse is raised. The destination moves past the written bytes only when it points into the advancing region (bit 24 set). While a transfer runs, register writes are dropped, and all three registers stay visible on the outputs.

Top module: `gfx_dma_chan`

## Requirements
- R1: After reset, dest_o, count_o, ctrl_o and done_o are all zero.
- R2: A destination write (reg_sel 0) stores (reg_wdata AND 0x03FFFFE0) OR 0x10000000 on dest_o.
- R3: A count write (reg_sel 1) stores reg_wdata AND 0x00FFFFE0 on count_o.
- R4: A control write (reg_sel 2) keeps only bit 0 of reg_wdata. A write with bit 0 set makes ctrl_o 1 and starts a transfer. A write with bit 0 clear leaves ctrl_o 0 and starts nothing.
- R5: While a transfer runs with a nonzero count, m_valid equals s_valid and s_ready equals m_ready. A byte is accepted when s_valid and m_ready are both high. The n-th accepted byte (from 0) is written with m_data equal to s_data at m_addr equal to dest_o plus n. While idle, m_valid and s_ready are 0.
- R6: When the accepted byte count reaches count_o, then in the next cycle ctrl_o and count_o are 0 and done_o is 1 for exactly one cycle.
- R7: At completion, dest_o grows by the number of bytes accepted if its bit 24 was set. Otherwise dest_o is unchanged.
- R8: An accepted byte with s_last high ends the transfer early, as in R6, and R7 then uses the number of bytes actually accepted.
- R9: Register writes of any select while ctrl_o is 1 change no register, and the transfer goes on unaffected.
- R10: A start with count_o equal to 0 accepts no byte. In the cycle after the start, ctrl_o is 0, done_o is 1 and dest_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 destination, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| dest_o | output | 32 | Current destination register |
| count_o | output | 32 | Current count register |
| ctrl_o | output | 1 | Control go bit (1 while a transfer runs) |
| s_valid | input | 1 | Input stream byte valid |
| s_data | input | 8 | Input stream byte |
| s_last | input | 1 | Input stream marks this byte as the final one |
| s_ready | output | 1 | Block accepts the stream byte |
| m_valid | output | 1 | Memory write request |
| m_addr | output | 32 | Memory byte address |
| m_data | output | 8 | Memory write byte |
| m_ready | input | 1 | Memory accepts the write |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Transfers run with valid and ready patterns that stall at random, so addresses must step only on real handshakes and never on idle cycles. Destinations with and without bit 24 separate the advancing region from the fixed one. Stream ends placed before, on and beyond the final counted byte separate an early stop from a normal count-based stop. Zero counts check the path that completes without any data. Writes injected during a transfer check that busy registers are locked. Masking is tried with all-ones and random write data.

// File: rtl/gfx_dma_pkg.sv
package gfx_dma_pkg;
  typedef enum logic [1:0] {
    SEL_DEST = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gfx_dma_regs.sv
module gfx_dma_regs #(
  parameter int AW        = 32,
  parameter int CW        = 24,
  parameter int ALIGN_LG  = 5,
  parameter int KEEP_W    = 26,
  parameter int REGION_B  = 28,
  parameter int ADV_B     = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          finish,
  input  logic [CW-1:0] adv,
  output logic [AW-1:0] dest_q,
  output logic [CW-1:0] count_q,
  output logic          go_q
);
  import gfx_dma_pkg::*;

  localparam logic [AW-1:0] DEST_KEEP =
    ((AW'(1) << KEEP_W) - AW'(1)) & ~((AW'(1) << ALIGN_LG) - AW'(1));
  localparam logic [AW-1:0] DEST_SET  = AW'(1) << REGION_B;
  localparam logic [CW-1:0] CNT_KEEP  = ~((CW'(1) << ALIGN_LG) - CW'(1));

  logic          idle_wr;
  logic          dest_en, cnt_en, go_en;
  logic [AW-1:0] dest_d;
  logic [CW-1:0] cnt_d;
  logic          go_d;
  logic          unused_hi;

  assign unused_hi = ^wr_data[AW-1:CW];
  assign idle_wr   = wr_en && !go_q;

  always_comb begin
    dest_en = 1'b0;
    cnt_en  = 1'b0;
    go_en   = 1'b0;
    dest_d  = dest_q;
    cnt_d   = count_q;
    go_d    = go_q;
    if (finish) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      go_en  = 1'b1;
      go_d   = 1'b0;
      if (dest_q[ADV_B]) begin
        dest_en = 1'b1;
        dest_d  = dest_q + {{(AW-CW){1'b0}}, adv};
      end
    end else if (idle_wr) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_DEST: begin
          dest_en = 1'b1;
          dest_d  = (wr_data & DEST_KEEP) | DEST_SET;
        end
        SEL_CNT: begin
          cnt_en = 1'b1;
          cnt_d  = wr_data[CW-1:0] & CNT_KEEP;
        end
        SEL_CTRL: begin
          go_en = 1'b1;
          go_d  = wr_data[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      count_q <= '0;
      go_q    <= 1'b0;
    end else begin
      if (dest_en) dest_q  <= dest_d;
      if (cnt_en)  count_q <= cnt_d;
      if (go_en)   go_q    <= go_d;
    end
  end
endmodule

// File: rtl/gfx_dma_mover.sv
module gfx_dma_mover #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic          m_ready,
  output logic          s_ready,
  output logic          m_valid,
  output logic [CW-1:0] sent,
  output logic          finish,
  output logic [CW-1:0] adv,
  output logic          done
);
  logic          run, fire, last_byte, empty_go;
  logic [CW-1:0] sent_plus, sent_d;
  logic          sent_en;

  assign run       = go && (count != '0);
  assign empty_go  = go && (count == '0);
  assign fire      = run && s_valid && m_ready;
  assign sent_plus = sent + CW'(1);
  assign last_byte = fire && ((sent_plus == count) || s_last);
  assign finish    = empty_go || last_byte;
  assign adv       = last_byte ? sent_plus : '0;
  assign s_ready   = run && m_ready;
  assign m_valid   = run && s_valid;

  always_comb begin
    sent_en = finish || fire;
    sent_d  = finish ? '0 : sent_plus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent <= '0;
      done <= 1'b0;
    end else begin
      if (sent_en) sent <= sent_d;
      done <= finish;
    end
  end
endmodule

// File: rtl/gfx_dma_chan.sv
module gfx_dma_chan #(
  parameter int AW       = 32,
  parameter int CW       = 24,
  parameter int DW       = 8,
  parameter int ALIGN_LG = 5,
  parameter int KEEP_W   = 26,
  parameter int REGION_B = 28,
  parameter int ADV_B    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] dest_o,
  output logic [AW-1:0] count_o,
  output logic          ctrl_o,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          m_valid,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  input  logic          m_ready,
  output logic          done_o
);
  localparam int PAD_W = AW - CW;

  logic [CW-1:0] count_q, sent, adv;
  logic          finish;

  gfx_dma_regs #(
    .AW(AW), .CW(CW), .ALIGN_LG(ALIGN_LG), .KEEP_W(KEEP_W),
    .REGION_B(REGION_B), .ADV_B(ADV_B)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .finish  (finish),
    .adv     (adv),
    .dest_q  (dest_o),
    .count_q (count_q),
    .go_q    (ctrl_o)
  );

  gfx_dma_mover #(.CW(CW)) u_mover (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (ctrl_o),
    .count   (count_q),
    .s_valid (s_valid),
    .s_last  (s_last),
    .m_ready (m_ready),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .sent    (sent),
    .finish  (finish),
    .adv     (adv),
    .done    (done_o)
  );

  assign count_o = {{PAD_W{1'b0}}, count_q};
  assign m_addr  = dest_o + {{PAD_W{1'b0}}, sent};
  assign m_data  = s_data;
endmodule

// File: rtl/gfx_dma_chan_chk.sv
module gfx_dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_o,
  input logic [AW-1:0] dest_o,
  input logic [AW-1:0] count_o,
  input logic          done_o,
  input logic          s_ready,
  input logic          m_valid
);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o |-> (!s_ready && !m_valid));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ctrl_o && count_o == '0));

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ctrl_o));

  p_busy_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o |=> (!ctrl_o || ($stable(dest_o) && $stable(count_o))));
endmodule

bind gfx_dma_chan gfx_dma_chan_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_o  (ctrl_o),
  .dest_o  (dest_o),
  .count_o (count_o),
  .done_o  (done_o),
  .s_ready (s_ready),
  .m_valid (m_valid)
);

// File: tb/test_gfx_dma_chan.sv
module test_gfx_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] dest_o, count_o, m_addr;
  logic        ctrl_o, s_valid, s_last, s_ready, m_valid, m_ready, done_o;
  logic [7:0]  s_data, m_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gfx_dma_chan i_gfx_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dest_o(dest_o), .count_o(count_o),
    .ctrl_o(ctrl_o), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data),
    .m_ready(m_ready), .done_o(done_o)
  );

  function automatic logic [31:0] exp_dest(input logic [31:0] v);
    return (v & 32'h03FF_FFE0) | 32'h1000_0000;
  endfunction

  function automatic logic [31:0] exp_cnt(input logic [31:0] v);
    return v & 32'h00FF_FFE0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] dval, input logic [31:0] cval,
                      input int last_idx, input bit poke);
    logic [31:0] ed, ec, fin;
    int nb, idx, cyc;
    reg_write(2'd0, dval);
    reg_write(2'd1, cval);
    ed = exp_dest(dval);
    ec = exp_cnt(cval);
    chk(dest_o == ed, "R2", dest_o, ed);
    chk(count_o == ec, "R3", count_o, ec);
    if (ec == 0) nb = 0;
    else if (last_idx >= 0 && last_idx < int'(ec)) nb = last_idx + 1;
    else nb = int'(ec);
    reg_write(2'd2, 32'h0000_0001);
    #1;
    chk(ctrl_o == 1'b1, "R4", {31'd0, ctrl_o}, 32'd1);
    idx = 0; cyc = 0;
    if (nb == 0) begin
      m_ready = 1'b1; s_valid = 1'b1;
      #1;
      chk(s_ready == 1'b0 && m_valid == 1'b0, "R10", {30'd0, s_ready, m_valid}, 32'd0);
      @(negedge clk);
      s_valid = 1'b0;
    end
    while (idx < nb) begin
      s_valid = ($urandom % 4) != 0;
      m_ready = ($urandom % 4) != 0;
      s_data  = 8'($urandom);
      s_last  = (idx == last_idx);
      if (poke && cyc == 1) begin
        reg_we = 1'b1; reg_sel = 2'($urandom % 3); reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
      end
      #1;
      chk(m_valid == s_valid && s_ready == m_ready, "R5",
          {30'd0, m_valid, s_ready}, {30'd0, s_valid, m_ready});
      if (s_valid && m_ready) begin
        chk(m_addr == ed + 32'(idx) && m_data == s_data, "R5", m_addr, ed + 32'(idx));
        idx++;
      end
      if (poke) chk(ctrl_o == 1'b1, "R9", {31'd0, ctrl_o}, 32'd1);
      cyc++;
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0; reg_we = 1'b0;
    #1;
    fin = ed[24] ? ed + 32'(nb) : ed;
    chk(done_o == 1'b1, (nb == 0) ? "R10" : "R6", {31'd0, done_o}, 32'd1);
    chk(ctrl_o == 1'b0 && count_o == 0, "R6", count_o, 32'd0);
    chk(dest_o == fin, (last_idx >= 0) ? "R8" : "R7", dest_o, fin);
    @(negedge clk);
    chk(done_o == 1'b0, "R6", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0; m_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dest_o == 0 && count_o == 0, "R1", dest_o | count_o, 32'd0);
    chk(!ctrl_o && !done_o, "R1", {30'd0, ctrl_o, done_o}, 32'd0);

    reg_write(2'd0, 32'hFFFF_FFFF);
    chk(dest_o == 32'h13FF_FFE0, "R2", dest_o, 32'h13FF_FFE0);
    reg_write(2'd1, 32'hFFFF_FFFF);
    chk(count_o == 32'h00FF_FFE0, "R3", count_o, 32'h00FF_FFE0);
    reg_write(2'd1, 32'd64);
    m_ready = 1'b1; s_valid = 1'b1;
    reg_write(2'd2, 32'h0000_0002);
    #1;
    chk(ctrl_o == 1'b0 && s_ready == 1'b0, "R4", {30'd0, ctrl_o, s_ready}, 32'd0);
    chk(dest_o == 32'h13FF_FFE0, "R4", dest_o, 32'h13FF_FFE0);
    s_valid = 1'b0;

    xfer(32'h0100_0040, 32'd32, -1, 1'b0);
    xfer(32'h0000_1000, 32'd64, -1, 1'b0);
    xfer(32'h0100_2000, 32'd64, 5, 1'b0);
    xfer(32'h0100_3000, 32'd32, 31, 1'b0);
    xfer(32'h0100_4000, 32'd32, 0, 1'b0);
    xfer(32'h0100_5000, 32'h0000_001F, -1, 1'b0);
    xfer(32'h0000_6000, 32'd0, -1, 1'b0);
    xfer(32'h0100_7000, 32'd96, -1, 1'b1);
    xfer(32'h0000_8000, 32'd64, 10, 1'b1);

    for (int k = 0; k < 14; k++) begin
      logic [31:0] dv, cv;
      int li;
      dv = $urandom;
      cv = (($urandom % 5) * 32) | ($urandom % 32);
      li = (($urandom % 3) == 0) ? int'($urandom % 100) : -1;
      xfer(dv, cv, li, ($urandom % 2) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule